// File: doc/BRIEF.md
# Dataflow Thread Ready Scheduler

This block decides when dataflow threads may run. A host creates a thread by giving it an identifier, a metadata word and a count of the inputs it still needs. Every time a producer delivers one output to that thread, a notification arrives on a separate port. Each notification lowers the thread's pending count by one. When the count reaches zero the thread is ready, and its identifier and metadata join an in-order ready queue.

A processor asks for work with a single-cycle request. One cycle later it gets a response: either the oldest ready thread, or a response with its valid flag low when the queue is empty. Notifications go into a small buffer and are applied in the background, so the producing processor is not held up.

The block also supports load balancing between nodes. Whenever the queue holds fewer entries than a programmable threshold, the block raises a steal request. Ready threads taken from other nodes come back on an inject port and enter the same queue, marked as remote.

Top module: `dfs_ready_sched`

## Requirements
- R1: A create stores the thread's metadata and initial pending count in the frame entry selected by its 6-bit identifier, and marks that entry valid. A create with a nonzero count releases the thread after exactly that many notifications. Creating an already-valid entry overwrites it.
- R2: Each applied notification lowers the target thread's count by one. Threads enter the ready queue in the order in which their counts reach zero.
- R3: A create whose initial count is zero enqueues the thread on the same clock edge. A request issued in the following cycle returns that thread.
- R4: Notifications are buffered. notify_ready_o stays high unless the buffer is full, so notifications sent on consecutive cycles are all applied.
- R5: When work_req_i is high on an edge, work_ack_o is high for one cycle after that edge. If the queue was not empty, that response has work_rsp_valid_o high and carries the oldest entry's identifier, metadata and remote flag (0 = local, 1 = injected), and the entry is removed from the queue.
- R6: A request made while the queue is empty returns work_ack_o high with work_rsp_valid_o low, and it removes nothing from the queue.
- R7: steal_req_o is high exactly when the queue occupancy is below steal_thresh_i.
- R8: A notification aimed at an entry that was never created, or at an entry whose count is already zero, changes nothing. It sets sync_err_o, which then stays high until reset.
- R9: When a create and a buffered notification target the same entry in the same cycle, the create is applied first. The notification is held and applied on a later cycle.
- R10: An injected thread enters the same ready queue with the remote flag set. When a local release and an injection happen on the same edge, the local thread is queued ahead of the injected one.
- R11: After reset the queue is empty, every frame entry is invalid, and work_ack_o and sync_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| create_valid_i | input | 1 | Create a thread this cycle |
| create_tid_i | input | 6 | Identifier of the thread being created |
| create_count_i | input | 8 | Initial pending-input count |
| create_meta_i | input | 16 | Thread metadata word |
| create_ready_o | output | 1 | Create accepted (queue has room for worst case) |
| notify_valid_i | input | 1 | A producer write was delivered |
| notify_tid_i | input | 6 | Consumer thread of that write |
| notify_ready_o | output | 1 | Notification buffer has room |
| inject_valid_i | input | 1 | Remote ready thread offered |
| inject_tid_i | input | 6 | Identifier of the remote thread |
| inject_meta_i | input | 16 | Metadata of the remote thread |
| inject_ready_o | output | 1 | Injection accepted |
| work_req_i | input | 1 | Processor asks for a thread |
| work_ack_o | output | 1 | Response strobe, one cycle after a request |
| work_rsp_valid_o | output | 1 | Response carries a thread |
| work_rsp_tid_o | output | 6 | Returned thread identifier |
| work_rsp_meta_o | output | 16 | Returned metadata |
| work_rsp_remote_o | output | 1 | Returned thread came from another node |
| steal_thresh_i | input | 7 | Occupancy threshold for stealing |
| steal_req_o | output | 1 | Request to fetch ready threads from other nodes |
| sync_err_o | output | 1 | Sticky bad-notification flag |

## Verification
Several properties are checked by assertions on every cycle: each request is followed by exactly one acknowledge, a valid response always comes with its acknowledge, an empty-queue request never yields a valid response, the error flag never drops once set, and the queue count never passes its depth. Some behaviours can only be shown by the directed scenarios. These are countdown release after the exact number of notifications, release order, the same-entry hold, local-before-remote ordering on one edge, and the steal request following occupancy. The scenarios also confirm that a bad notification leaves the queue unchanged.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int TID_W  = 6;
  localparam int META_W = 16;
  localparam int CNT_W  = 8;
  localparam int N_THR  = 1 << TID_W;

  typedef struct packed {
    logic              remote;
    logic [TID_W-1:0]  tid;
    logic [META_W-1:0] meta;
  } rq_ent_t;
endpackage

// File: rtl/dfs_sync_fifo.sv
// DEPTH must be a power of two; pointers wrap naturally.
module dfs_sync_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + AW'(push_i);
      rp_q  <= rp_q + AW'(pop_i);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/dfs_frame_table.sv
module dfs_frame_table import dfs_pkg::*; #(
  parameter int N = N_THR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cr_en_i,
  input  logic [TID_W-1:0]  cr_tid_i,
  input  logic [CNT_W-1:0]  cr_cnt_i,
  input  logic [META_W-1:0] cr_meta_i,
  input  logic              dec_en_i,
  input  logic [TID_W-1:0]  dec_tid_i,
  output logic              dec_rel_o,
  output logic [META_W-1:0] dec_meta_o,
  output logic              dec_err_o
);
  logic [CNT_W-1:0]  cnt_q  [N];
  logic [META_W-1:0] meta_q [N];
  logic [N-1:0]      vld_q;
  logic              dec_ok;

  always_comb begin
    dec_ok     = dec_en_i && vld_q[dec_tid_i] && (cnt_q[dec_tid_i] != '0);
    dec_rel_o  = dec_ok && (cnt_q[dec_tid_i] == CNT_W'(1));
    dec_err_o  = dec_en_i && !dec_ok;
    dec_meta_o = meta_q[dec_tid_i];
  end

  // caller guarantees cr_tid_i != dec_tid_i when both are enabled
  always_ff @(posedge clk_i) begin
    if (dec_ok) cnt_q[dec_tid_i] <= cnt_q[dec_tid_i] - CNT_W'(1);
    if (cr_en_i) begin
      cnt_q[cr_tid_i]  <= cr_cnt_i;
      meta_q[cr_tid_i] <= cr_meta_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (cr_en_i) vld_q[cr_tid_i] <= 1'b1;
  end
endmodule

// File: rtl/dfs_ready_queue.sv
// Multi-push FIFO: lower push index is queued first. DEPTH must be a power of two.
module dfs_ready_queue import dfs_pkg::*; #(
  parameter  int DEPTH = 64,
  parameter  int NP    = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NP-1:0]       push_i,
  input  rq_ent_t [NP-1:0]    data_i,
  input  logic                pop_i,
  output rq_ent_t             head_o,
  output logic [CW-1:0]       count_o
);
  rq_ent_t       mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] slot [NP];
  logic [CW-1:0] n_push;

  always_comb begin
    n_push = '0;
    for (int k = 0; k < NP; k++) begin
      slot[k] = wp_q + AW'(n_push);
      n_push  = n_push + CW'(push_i[k]);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < NP; k++)
      if (push_i[k]) mem[slot[k]] <= data_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + AW'(n_push);
      rp_q  <= rp_q + AW'(pop_i);
      cnt_q <= cnt_q + n_push - CW'(pop_i);
    end
  end

  assign head_o  = mem[rp_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/dfs_ready_sched.sv
module dfs_ready_sched import dfs_pkg::*; #(
  parameter  int Q_DEPTH  = 64,
  parameter  int NF_DEPTH = 4,
  localparam int QC_W     = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              create_valid_i,
  input  logic [TID_W-1:0]  create_tid_i,
  input  logic [CNT_W-1:0]  create_count_i,
  input  logic [META_W-1:0] create_meta_i,
  output logic              create_ready_o,
  input  logic              notify_valid_i,
  input  logic [TID_W-1:0]  notify_tid_i,
  output logic              notify_ready_o,
  input  logic              inject_valid_i,
  input  logic [TID_W-1:0]  inject_tid_i,
  input  logic [META_W-1:0] inject_meta_i,
  output logic              inject_ready_o,
  input  logic              work_req_i,
  output logic              work_ack_o,
  output logic              work_rsp_valid_o,
  output logic [TID_W-1:0]  work_rsp_tid_o,
  output logic [META_W-1:0] work_rsp_meta_o,
  output logic              work_rsp_remote_o,
  input  logic [QC_W-1:0]   steal_thresh_i,
  output logic              steal_req_o,
  output logic              sync_err_o
);
  localparam int NP = 3;  // push ports: create release, countdown release, inject

  logic [QC_W-1:0]  q_cnt, q_free;
  rq_ent_t          q_head;
  logic [NP-1:0]    q_push;
  rq_ent_t [NP-1:0] q_data;
  logic             q_pop;

  logic             nf_full, nf_empty, nf_pop;
  logic [TID_W-1:0] nf_tid;

  logic              cr_fire, dec_en, dec_rel, dec_err;
  logic [META_W-1:0] dec_meta;

  logic              ack_q, rsp_vld_q, rsp_rem_q, err_q;
  logic [TID_W-1:0]  rsp_tid_q;
  logic [META_W-1:0] rsp_meta_q;

  // Admission: reserve room for every push that may land this cycle.
  assign q_free         = QC_W'(Q_DEPTH) - q_cnt;
  assign create_ready_o = (q_free >= QC_W'(2));
  assign inject_ready_o = (q_free >= QC_W'(3));
  assign notify_ready_o = !nf_full;

  assign cr_fire = create_valid_i && create_ready_o;
  // hold a same-entry decrement behind the create
  assign dec_en  = !nf_empty && (q_free >= QC_W'(2)) &&
                   !(cr_fire && (create_tid_i == nf_tid));
  assign nf_pop  = dec_en;

  dfs_sync_fifo #(.W(TID_W), .DEPTH(NF_DEPTH)) u_notify_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (notify_valid_i && !nf_full),
    .data_i  (notify_tid_i),
    .pop_i   (nf_pop),
    .data_o  (nf_tid),
    .empty_o (nf_empty),
    .full_o  (nf_full)
  );

  dfs_frame_table u_frames (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cr_en_i    (cr_fire),
    .cr_tid_i   (create_tid_i),
    .cr_cnt_i   (create_count_i),
    .cr_meta_i  (create_meta_i),
    .dec_en_i   (dec_en),
    .dec_tid_i  (nf_tid),
    .dec_rel_o  (dec_rel),
    .dec_meta_o (dec_meta),
    .dec_err_o  (dec_err)
  );

  always_comb begin
    q_push[0] = cr_fire && (create_count_i == '0);
    q_data[0] = '{remote: 1'b0, tid: create_tid_i, meta: create_meta_i};
    q_push[1] = dec_rel;
    q_data[1] = '{remote: 1'b0, tid: nf_tid, meta: dec_meta};
    q_push[2] = inject_valid_i && inject_ready_o;
    q_data[2] = '{remote: 1'b1, tid: inject_tid_i, meta: inject_meta_i};
  end

  assign q_pop = work_req_i && (q_cnt != '0);

  dfs_ready_queue #(.DEPTH(Q_DEPTH), .NP(NP)) u_ready_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .data_i  (q_data),
    .pop_i   (q_pop),
    .head_o  (q_head),
    .count_o (q_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q      <= 1'b0;
      rsp_vld_q  <= 1'b0;
      rsp_tid_q  <= '0;
      rsp_meta_q <= '0;
      rsp_rem_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      ack_q     <= work_req_i;
      rsp_vld_q <= q_pop;
      if (q_pop) begin
        rsp_tid_q  <= q_head.tid;
        rsp_meta_q <= q_head.meta;
        rsp_rem_q  <= q_head.remote;
      end
      if (dec_err) err_q <= 1'b1;
    end
  end

  assign work_ack_o        = ack_q;
  assign work_rsp_valid_o  = rsp_vld_q;
  assign work_rsp_tid_o    = rsp_tid_q;
  assign work_rsp_meta_o   = rsp_meta_q;
  assign work_rsp_remote_o = rsp_rem_q;
  assign steal_req_o       = (q_cnt < steal_thresh_i);
  assign sync_err_o        = err_q;
endmodule

// File: rtl/dfs_ready_sched_chk.sv
module dfs_ready_sched_chk #(
  parameter  int Q_DEPTH = 64,
  localparam int QC_W    = $clog2(Q_DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            work_req_i,
  input logic            work_ack_o,
  input logic            work_rsp_valid_o,
  input logic            sync_err_o,
  input logic [QC_W-1:0] q_cnt_i
);
  a_r5_ack_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    work_req_i |=> work_ack_o);

  a_r5_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    work_ack_o |-> $past(work_req_i));

  a_r6_valid_has_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    work_rsp_valid_o |-> work_ack_o);

  a_r6_empty_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (work_req_i && q_cnt_i == '0) |=> !work_rsp_valid_o);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |=> sync_err_o);

  a_r10_queue_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt_i <= QC_W'(Q_DEPTH));
endmodule

bind dfs_ready_sched dfs_ready_sched_chk #(.Q_DEPTH(Q_DEPTH)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .work_req_i       (work_req_i),
  .work_ack_o       (work_ack_o),
  .work_rsp_valid_o (work_rsp_valid_o),
  .sync_err_o       (sync_err_o),
  .q_cnt_i          (q_cnt)
);

// File: tb/tb_dfs_ready_sched.sv
`timescale 1ns/1ps
module tb_dfs_ready_sched;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        create_valid_i = 0;
  logic [5:0]  create_tid_i = 0;
  logic [7:0]  create_count_i = 0;
  logic [15:0] create_meta_i = 0;
  logic        create_ready_o;
  logic        notify_valid_i = 0;
  logic [5:0]  notify_tid_i = 0;
  logic        notify_ready_o;
  logic        inject_valid_i = 0;
  logic [5:0]  inject_tid_i = 0;
  logic [15:0] inject_meta_i = 0;
  logic        inject_ready_o;
  logic        work_req_i = 0;
  logic        work_ack_o, work_rsp_valid_o, work_rsp_remote_o;
  logic [5:0]  work_rsp_tid_o;
  logic [15:0] work_rsp_meta_o;
  logic [6:0]  steal_thresh_i = 7'd2;
  logic        steal_req_o, sync_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dfs_ready_sched dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .create_valid_i(create_valid_i), .create_tid_i(create_tid_i),
    .create_count_i(create_count_i), .create_meta_i(create_meta_i),
    .create_ready_o(create_ready_o),
    .notify_valid_i(notify_valid_i), .notify_tid_i(notify_tid_i),
    .notify_ready_o(notify_ready_o),
    .inject_valid_i(inject_valid_i), .inject_tid_i(inject_tid_i),
    .inject_meta_i(inject_meta_i), .inject_ready_o(inject_ready_o),
    .work_req_i(work_req_i), .work_ack_o(work_ack_o),
    .work_rsp_valid_o(work_rsp_valid_o), .work_rsp_tid_o(work_rsp_tid_o),
    .work_rsp_meta_o(work_rsp_meta_o), .work_rsp_remote_o(work_rsp_remote_o),
    .steal_thresh_i(steal_thresh_i), .steal_req_o(steal_req_o),
    .sync_err_o(sync_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_ni = 1'b0;
    create_valid_i = 0; notify_valid_i = 0; inject_valid_i = 0; work_req_i = 0;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic do_create(input int tid, input int cnt, input int meta);
    create_valid_i = 1; create_tid_i = 6'(tid);
    create_count_i = 8'(cnt); create_meta_i = 16'(meta);
    @(negedge clk);
    create_valid_i = 0;
  endtask

  task automatic do_notify(input int tid);
    notify_valid_i = 1; notify_tid_i = 6'(tid);
    @(negedge clk);
    notify_valid_i = 0;
  endtask

  // one request; checks ack, valid and, when valid, the returned entry
  task automatic do_pop(input string tag, input bit exp_vld, input int exp_tid,
                        input int exp_meta, input bit exp_rem);
    work_req_i = 1;
    @(negedge clk);
    work_req_i = 0;
    chk({tag, " ack"}, int'(work_ack_o), 1);
    chk({tag, " valid"}, int'(work_rsp_valid_o), int'(exp_vld));
    if (exp_vld) begin
      chk({tag, " tid"}, int'(work_rsp_tid_o), exp_tid);
      chk({tag, " meta"}, int'(work_rsp_meta_o), exp_meta);
      chk({tag, " remote"}, int'(work_rsp_remote_o), int'(exp_rem));
    end
  endtask

  task automatic t_reset_state();
    chk("R11 ack low", int'(work_ack_o), 0);
    chk("R11 err low", int'(sync_err_o), 0);
    chk("R11 steal with empty queue (R7)", int'(steal_req_o), 1);
    chk("R11 create ready", int'(create_ready_o), 1);
    chk("R4 notify ready idle", int'(notify_ready_o), 1);
    do_pop("R11 queue empty", 0, 0, 0, 0);
  endtask

  task automatic t_zero_create();
    do_create(5, 0, 16'h1234);
    do_pop("R3 immediate release R5", 1, 5, 16'h1234, 0);
  endtask

  task automatic t_countdown();
    do_create(10, 3, 16'hAAAA);
    do_notify(10);
    do_notify(10);
    idle(1);
    do_pop("R1 not released early R6", 0, 0, 0, 0);
    do_notify(10);
    idle(1);
    do_pop("R1 release after count", 1, 10, 16'hAAAA, 0);
  endtask

  task automatic t_order();
    do_create(1, 1, 16'h0101);
    do_create(2, 1, 16'h0202);
    do_create(3, 1, 16'h0303);
    do_notify(3);
    do_notify(1);
    do_notify(2);
    idle(1);
    chk("R7 steal low at 3 entries", int'(steal_req_o), 0);
    do_pop("R2 order first", 1, 3, 16'h0303, 0);
    do_pop("R2 order second", 1, 1, 16'h0101, 0);
    chk("R7 steal high at 1 entry", int'(steal_req_o), 1);
    do_pop("R2 order third", 1, 2, 16'h0202, 0);
  endtask

  task automatic t_burst();
    do_create(30, 4, 16'h3030);
    chk("R4 ready before burst", int'(notify_ready_o), 1);
    notify_valid_i = 1; notify_tid_i = 6'd30;
    idle(4);
    notify_valid_i = 0;
    idle(2);
    do_pop("R4 burst all applied", 1, 30, 16'h3030, 0);
  endtask

  task automatic t_conflict();
    create_valid_i = 1; create_tid_i = 6'd20; create_count_i = 8'd1;
    create_meta_i = 16'h2001;
    notify_valid_i = 1; notify_tid_i = 6'd20;
    @(negedge clk);
    notify_valid_i = 0;
    create_count_i = 8'd2; create_meta_i = 16'h2002;
    @(negedge clk);
    create_valid_i = 0;
    idle(2);
    do_pop("R9 held decrement leaves one pending", 0, 0, 0, 0);
    chk("R9 no error", int'(sync_err_o), 0);
    do_notify(20);
    idle(1);
    do_pop("R9 release after second decrement", 1, 20, 16'h2002, 0);
  endtask

  task automatic t_local_remote();
    create_valid_i = 1; create_tid_i = 6'd7; create_count_i = 8'd0;
    create_meta_i = 16'h7777;
    inject_valid_i = 1; inject_tid_i = 6'd9; inject_meta_i = 16'h9999;
    chk("R10 inject ready", int'(inject_ready_o), 1);
    @(negedge clk);
    create_valid_i = 0; inject_valid_i = 0;
    do_pop("R10 local first", 1, 7, 16'h7777, 0);
    do_pop("R10 remote second", 1, 9, 16'h9999, 1);
  endtask

  task automatic t_err_zero();
    do_notify(5);
    idle(1);
    chk("R8 err on zero count", int'(sync_err_o), 1);
    do_pop("R8 zero-count decrement no release", 0, 0, 0, 0);
    idle(2);
    chk("R8 err sticky", int'(sync_err_o), 1);
  endtask

  task automatic t_err_invalid();
    chk("R11 err cleared by reset", int'(sync_err_o), 0);
    do_notify(40);
    idle(1);
    chk("R8 err on invalid entry", int'(sync_err_o), 1);
    do_pop("R8 invalid decrement no release", 0, 0, 0, 0);
  endtask

  initial begin
    idle(1);
    apply_reset();
    t_reset_state();
    t_zero_create();
    t_countdown();
    t_order();
    t_burst();
    t_conflict();
    t_local_remote();
    t_err_zero();
    apply_reset();
    t_err_invalid();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule